// File: doc/BRIEF.md
# Memory User Bus Master

This block is the single master of a shared register-style bus that links several memory users to one frame-buffer memory port. Each user raises its own request line and is serviced through its own select line. The bus carries a strobe, a read/write flag, a 12-bit word address and 32-bit data. The data path is split into one direction out of the master and one direction back into it. The user logic places the addressed register of whichever user is selected on the return lane.

When the master is idle it chooses one requesting user. Users with the lowest indices (`N_DISP` of them) feed display caches and always win, the lowest index first. The remaining users take turns in rotation. The master selects the chosen user and reads two descriptor words from the top of that user's register space. The first word gives the direction and the length in words. The second gives the starting frame-buffer address. The master then moves the requested words one at a time between user addresses 0, 1, 2… and consecutive frame-buffer addresses. The frame-buffer side is a request/acknowledge port. When the transfer ends, or the port reports an error, the master deselects the user.

Top module: `mub_master`

## Requirements
- R1: At most one select bit is high at any time. Strobe is high only while some select is high. After a select falls, all selects stay low for at least one cycle, and the user must drop its request within that cycle. Request lines are sampled only while idle.
- R2: Among pending requests, a display-cache user (index below `N_DISP`) is always chosen first, and the lowest such index wins.
- R3: Among the other users, the search starts at the one after the last ordinary user served and wraps around. After reset the search starts at the first ordinary user (index `N_DISP`).
- R4: The select rises together with a read strobe (write flag low) at word address 0xFFC. The next cycle has a read strobe at 0xFFD. Each read strobe lasts one cycle, and the master captures the return lane at the clock edge that ends it.
- R5: In the word read from 0xFFC, bit 31 set means user-to-frame-buffer and bit 31 clear means frame-buffer-to-user. Bits 23:0 give the count of 32-bit words. The word read from 0xFFD is the first frame-buffer address.
- R6: Beat i uses user word address i and frame-buffer address start+i. Beats run in increasing order. Each beat consists of one user strobe and one frame-buffer handshake, and the bus and the frame-buffer port are never active in the same cycle.
- R7: Once raised, the frame-buffer request stays high until acknowledge is seen. Address, write flag and write data stay unchanged while it waits.
- R8: A length of zero deselects the user right after the descriptor, with no frame-buffer request.
- R9: An acknowledge that comes with the error flag ends the service. On the next cycle select, strobe and request are all low.
- R10: Once a user is selected, the select value does not change until it returns to zero, whatever other requests arrive.
- R11: While reset is high and just after it, all selects, the strobe and the frame-buffer request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| usr_irq | input | N_USERS | per-user service request |
| usr_sel | output | N_USERS | per-user select, one-hot or zero |
| bus_stb | output | 1 | bus access strobe |
| bus_wr | output | 1 | high: user stores bus_wdata; low: user drives bus_rdata |
| bus_addr | output | AW | user word address |
| bus_wdata | output | DW | data from master to user |
| bus_rdata | input | DW | data from selected user to master |
| fb_req | output | 1 | frame-buffer access request |
| fb_we | output | 1 | frame-buffer write when high |
| fb_addr | output | DW | frame-buffer word address |
| fb_wdata | output | DW | frame-buffer write data |
| fb_rdata | input | DW | frame-buffer read data, valid with fb_ack |
| fb_ack | input | 1 | frame-buffer access done |
| fb_err | input | 1 | frame-buffer access failed, valid with fb_ack |

## Verification
A corrupted rotation pointer or priority decision shows up on the first rising select after it. That select is a different bit than the one predicted from the request lines of the cycle before. A wrong beat counter, address counter or direction latch shows up at the first data strobe or the first acknowledged frame-buffer access. Either one carries an address, write flag or data word that differs from the predicted sequence. A state machine that stalls or overruns appears when the select falls: the transfer queue is still non-empty, or a strobe arrives that nothing predicted. A lost error abort appears one cycle after the failing acknowledge.

// File: rtl/mub_pkg.sv
package mub_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a request
    S_DCMD,   // strobe on command/length word
    S_DBASE,  // strobe on start-address word
    S_URD,    // strobe reading a user data word
    S_FBW,    // frame-buffer write in flight
    S_FBR,    // frame-buffer read in flight
    S_UWR,    // strobe writing a user data word
    S_DONE    // select low, one quiet cycle
  } mub_state_t;

endpackage

// File: rtl/mub_pick.sv
module mub_pick #(
  parameter int N_USERS = 4,
  parameter int N_DISP  = 2
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [N_USERS-1:0]                        irq,
  input  logic                                      take,
  output logic                                      any,
  output logic [((N_USERS > 1) ? $clog2(N_USERS) : 1)-1:0] idx
);
  localparam int IW    = (N_USERS > 1) ? $clog2(N_USERS) : 1;
  localparam int N_ORD = N_USERS - N_DISP;
  localparam int OW    = (N_ORD > 1) ? $clog2(N_ORD) : 1;

  logic [OW-1:0] ptr;
  logic [OW-1:0] ptr_nxt;
  logic          ord_win;

  // two-tier search: fixed order over display users, rotating over the rest
  always_comb begin
    int j;
    j       = 0;
    any     = 1'b0;
    idx     = '0;
    ord_win = 1'b0;
    ptr_nxt = ptr;
    for (int d = 0; d < N_DISP; d++) begin
      if (!any && irq[d]) begin
        any = 1'b1;
        idx = IW'(d);
      end
    end
    for (int k = 0; k < N_ORD; k++) begin
      j = (int'(ptr) + k) % N_ORD;
      if (!any && irq[N_DISP + j]) begin
        any     = 1'b1;
        ord_win = 1'b1;
        idx     = IW'(N_DISP + j);
        ptr_nxt = OW'((j + 1) % N_ORD);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (take && ord_win) begin
      ptr <= ptr_nxt;
    end
  end

endmodule

// File: rtl/mub_ctl.sv
module mub_ctl
  import mub_pkg::*;
#(
  parameter int N_USERS = 4,
  parameter int IW      = 2,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int LW      = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_any,
  input  logic [IW-1:0]      req_idx,
  output logic               take,
  output logic [N_USERS-1:0] usr_sel,
  output logic               bus_stb,
  output logic               bus_wr,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  output logic               fb_req,
  output logic               fb_we,
  output logic [DW-1:0]      fb_addr,
  output logic [DW-1:0]      fb_wdata,
  input  logic [DW-1:0]      fb_rdata,
  input  logic               fb_ack,
  input  logic               fb_err
);
  // descriptor words live in the top four words of each user's space
  localparam logic [AW-1:0] A_CMD  = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [AW-1:0] A_BASE = {{(AW-2){1'b1}}, 2'b01};
  localparam int            DIR_BIT = DW - 1;

  mub_state_t    state;
  logic          to_fb;
  logic [LW-1:0] remain;
  logic [AW-1:0] uidx;
  logic          last_beat;

  assign take      = (state == S_IDLE) && req_any;
  assign last_beat = (remain == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      usr_sel   <= '0;
      bus_stb   <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      fb_req    <= 1'b0;
      fb_we     <= 1'b0;
      fb_addr   <= '0;
      fb_wdata  <= '0;
      to_fb     <= 1'b0;
      remain    <= '0;
      uidx      <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (req_any) begin
            usr_sel  <= N_USERS'(1) << req_idx;
            bus_stb  <= 1'b1;
            bus_wr   <= 1'b0;
            bus_addr <= A_CMD;
            state    <= S_DCMD;
          end
        end
        S_DCMD: begin
          to_fb    <= bus_rdata[DIR_BIT];
          remain   <= bus_rdata[LW-1:0];
          uidx     <= '0;
          bus_addr <= A_BASE;
          state    <= S_DBASE;
        end
        S_DBASE: begin
          fb_addr <= bus_rdata;
          if (remain == '0) begin
            bus_stb <= 1'b0;
            usr_sel <= '0;
            state   <= S_DONE;
          end else if (to_fb) begin
            bus_addr <= '0;
            state    <= S_URD;
          end else begin
            bus_stb <= 1'b0;
            fb_req  <= 1'b1;
            fb_we   <= 1'b0;
            state   <= S_FBR;
          end
        end
        S_URD: begin
          fb_wdata <= bus_rdata;
          bus_stb  <= 1'b0;
          fb_req   <= 1'b1;
          fb_we    <= 1'b1;
          state    <= S_FBW;
        end
        S_FBW: begin
          if (fb_ack) begin
            fb_req  <= 1'b0;
            fb_we   <= 1'b0;
            fb_addr <= fb_addr + DW'(1);
            remain  <= remain - LW'(1);
            uidx    <= uidx + AW'(1);
            if (fb_err || last_beat) begin
              usr_sel <= '0;
              state   <= S_DONE;
            end else begin
              bus_stb  <= 1'b1;
              bus_wr   <= 1'b0;
              bus_addr <= uidx + AW'(1);
              state    <= S_URD;
            end
          end
        end
        S_FBR: begin
          if (fb_ack) begin
            fb_req <= 1'b0;
            if (fb_err) begin
              usr_sel <= '0;
              state   <= S_DONE;
            end else begin
              bus_wdata <= fb_rdata;
              bus_stb   <= 1'b1;
              bus_wr    <= 1'b1;
              bus_addr  <= uidx;
              state     <= S_UWR;
            end
          end
        end
        S_UWR: begin
          bus_stb <= 1'b0;
          bus_wr  <= 1'b0;
          fb_addr <= fb_addr + DW'(1);
          remain  <= remain - LW'(1);
          uidx    <= uidx + AW'(1);
          if (last_beat) begin
            usr_sel <= '0;
            state   <= S_DONE;
          end else begin
            fb_req <= 1'b1;
            state  <= S_FBR;
          end
        end
        S_DONE: begin
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mub_master.sv
module mub_master #(
  parameter int N_USERS = 4,
  parameter int N_DISP  = 2,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int LW      = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_USERS-1:0] usr_irq,
  output logic [N_USERS-1:0] usr_sel,
  output logic               bus_stb,
  output logic               bus_wr,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_wdata,
  input  logic [DW-1:0]      bus_rdata,
  output logic               fb_req,
  output logic               fb_we,
  output logic [DW-1:0]      fb_addr,
  output logic [DW-1:0]      fb_wdata,
  input  logic [DW-1:0]      fb_rdata,
  input  logic               fb_ack,
  input  logic               fb_err
);
  localparam int IW = (N_USERS > 1) ? $clog2(N_USERS) : 1;

  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic          pick_take;

  mub_pick #(
    .N_USERS (N_USERS),
    .N_DISP  (N_DISP)
  ) u_pick (
    .clk  (clk),
    .rst  (rst),
    .irq  (usr_irq),
    .take (pick_take),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  mub_ctl #(
    .N_USERS (N_USERS),
    .IW      (IW),
    .AW      (AW),
    .DW      (DW),
    .LW      (LW)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .req_any   (pick_any),
    .req_idx   (pick_idx),
    .take      (pick_take),
    .usr_sel   (usr_sel),
    .bus_stb   (bus_stb),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .fb_req    (fb_req),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata),
    .fb_rdata  (fb_rdata),
    .fb_ack    (fb_ack),
    .fb_err    (fb_err)
  );

endmodule

// File: rtl/mub_master_chk.sv
module mub_master_chk #(
  parameter int N_USERS = 4,
  parameter int N_DISP  = 2,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [N_USERS-1:0] usr_irq,
  input logic [N_USERS-1:0] usr_sel,
  input logic               bus_stb,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic               fb_req,
  input logic               fb_we,
  input logic [DW-1:0]      fb_addr,
  input logic [DW-1:0]      fb_wdata,
  input logic               fb_ack,
  input logic               fb_err
);
  localparam logic [AW-1:0]      A_CMD  = {{(AW-2){1'b1}}, 2'b00};
  localparam logic [AW-1:0]      A_BASE = {{(AW-2){1'b1}}, 2'b01};
  localparam logic [N_USERS-1:0] DMASK  = N_USERS'((1 << N_DISP) - 1);

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(usr_sel));

  a_r1_stb_needs_sel: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> (usr_sel != '0));

  a_r1_quiet_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(|usr_sel) |=> (usr_sel == '0));

  a_r2_display_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(|usr_sel) && (($past(usr_irq) & DMASK) != '0)) |-> ((usr_sel & DMASK) != '0));

  a_r4_cmd_first: assert property (@(posedge clk) disable iff (rst)
    $rose(|usr_sel) |-> (bus_stb && !bus_wr && bus_addr == A_CMD));

  a_r4_base_second: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_wr && bus_addr == A_CMD) |=> (bus_stb && !bus_wr && bus_addr == A_BASE));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(bus_stb && fb_req));

  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (fb_req && !fb_ack) |=> (fb_req && $stable(fb_addr) && $stable(fb_we) && $stable(fb_wdata)));

  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (fb_req && fb_ack && fb_err) |=> (usr_sel == '0 && !fb_req && !bus_stb));

  a_r10_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (usr_sel != '0) |=> (usr_sel == '0 || $stable(usr_sel)));

endmodule

bind mub_master mub_master_chk #(
  .N_USERS (N_USERS),
  .N_DISP  (N_DISP),
  .AW      (AW),
  .DW      (DW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .usr_irq  (usr_irq),
  .usr_sel  (usr_sel),
  .bus_stb  (bus_stb),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .fb_req   (fb_req),
  .fb_we    (fb_we),
  .fb_addr  (fb_addr),
  .fb_wdata (fb_wdata),
  .fb_ack   (fb_ack),
  .fb_err   (fb_err)
);

// File: tb/mub_master_bench.sv
module mub_master_bench;
  localparam int NU = 4;
  localparam int ND = 2;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NU-1:0] usr_irq = '0;
  logic [NU-1:0] usr_sel;
  logic          bus_stb, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          fb_req, fb_we;
  logic [DW-1:0] fb_addr, fb_wdata;
  logic [DW-1:0] fb_rdata = '0;
  logic          fb_ack = 1'b0;
  logic          fb_err = 1'b0;

  mub_master #(.N_USERS(NU), .N_DISP(ND), .AW(AW), .DW(DW), .LW(24)) u_mub_master (
    .clk(clk), .rst(rst), .usr_irq(usr_irq), .usr_sel(usr_sel),
    .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .fb_ack(fb_ack), .fb_err(fb_err)
  );

  // behavioural users and frame buffer
  logic [31:0] umem [NU][16];
  logic [31:0] dcmd [NU];
  logic [31:0] dbase [NU];
  logic [31:0] fbm [64];
  int  fb_lat = 0;
  int  lat_cnt = 0;
  bit  err_arm = 1'b0;
  logic [NU-1:0] sel_prev = '0;

  int nvec = 0, nbad = 0, nack = 0, cycles = 0;
  int picks[$];

  function automatic int sel_idx(logic [NU-1:0] s);
    for (int i = 0; i < NU; i++) if (s[i]) return i;
    return 0;
  endfunction

  always_comb begin
    if (usr_sel == '0)              bus_rdata = '0;
    else if (bus_addr == 12'hFFC)   bus_rdata = dcmd[sel_idx(usr_sel)];
    else if (bus_addr == 12'hFFD)   bus_rdata = dbase[sel_idx(usr_sel)];
    else                            bus_rdata = umem[sel_idx(usr_sel)][bus_addr[3:0]];
  end

  always @(posedge clk) begin
    if (bus_stb && bus_wr && usr_sel != '0)
      umem[sel_idx(usr_sel)][bus_addr[3:0]] <= bus_wdata;
    for (int i = 0; i < NU; i++)
      if (sel_prev[i] && !usr_sel[i]) usr_irq[i] <= 1'b0;
    sel_prev <= usr_sel;
    if (fb_req && !fb_ack) begin
      if (lat_cnt >= fb_lat) begin
        fb_ack   <= 1'b1;
        fb_err   <= err_arm;
        fb_rdata <= fbm[fb_addr[5:0]];
        lat_cnt  <= 0;
        if (fb_we && !err_arm) fbm[fb_addr[5:0]] <= fb_wdata;
        if (err_arm) err_arm <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      fb_ack <= 1'b0;
      fb_err <= 1'b0;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_pick(logic [NU-1:0] r, int p);
    for (int d = 0; d < ND; d++) if (r[d]) return d;
    for (int k = 0; k < NU - ND; k++)
      if (r[ND + (p + k) % (NU - ND)]) return ND + (p + k) % (NU - ND);
    return -1;
  endfunction

  // reference model: predicted selection, bus access and frame-buffer access queues
  logic [44:0] qb[$];
  logic [64:0] qf[$];
  int  cur = -1;
  int  mptr = 0;
  logic [NU-1:0] irq_q = '0;
  bit  aborted = 1'b0, chk_abort = 1'b0;
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_we = 1'b0;
  logic [DW-1:0] prev_addr = '0, prev_wd = '0;

  always @(negedge clk) begin
    int e; int len; bit tofb;
    logic [44:0] hb; logic [64:0] hf;
    if (!rst) begin
      if (chk_abort) begin
        chk(usr_sel == '0 && !bus_stb && !fb_req, "R9 abort ends service",
            {bus_stb, fb_req, usr_sel}, 0);
        chk_abort = 1'b0;
      end
      if (cur >= 0) begin
        if (usr_sel == '0) begin
          if (!aborted)
            chk(qb.size() == 0 && qf.size() == 0, "R6 all beats done before deselect",
                qb.size() + qf.size(), 0);
          cur = -1;
          aborted = 1'b0;
        end else begin
          chk(usr_sel == NU'(1) << cur, "R10 select held during service", usr_sel, NU'(1) << cur);
        end
      end else if (usr_sel != '0) begin
        e = exp_pick(irq_q, mptr);
        chk(e >= 0 && usr_sel == NU'(1) << e, (e < ND) ? "R2 display priority" : "R3 round robin",
            usr_sel, (e >= 0) ? (64'd1 << e) : 64'd0);
        cur = sel_idx(usr_sel);
        picks.push_back(cur);
        if (cur >= ND) mptr = (cur - ND + 1) % (NU - ND);
        len  = int'(dcmd[cur][23:0]);
        tofb = dcmd[cur][31];
        qb.push_back({1'b0, 12'hFFC, 32'h0});
        qb.push_back({1'b0, 12'hFFD, 32'h0});
        for (int i = 0; i < len; i++) begin
          qb.push_back({!tofb, 12'(i), tofb ? 32'h0 : fbm[6'(dbase[cur] + 32'(i))]});
          qf.push_back({tofb, dbase[cur] + 32'(i), tofb ? umem[cur][4'(i)] : 32'h0});
        end
      end else begin
        chk(!bus_stb && !fb_req, "R1 idle bus quiet", {bus_stb, fb_req}, 0);
      end
      if (bus_stb) begin
        if (qb.size() == 0) chk(1'b0, "R4 unexpected strobe", bus_addr, 0);
        else begin
          hb = qb.pop_front();
          chk(bus_wr == hb[44] && bus_addr == hb[43:32] && (!hb[44] || bus_wdata == hb[31:0]),
              "R4 R6 bus access order", {bus_wr, bus_addr, bus_wdata}, hb);
        end
      end
      if (fb_req && prev_req && !prev_ack)
        chk(fb_addr == prev_addr && fb_we == prev_we && fb_wdata == prev_wd,
            "R7 request held stable", fb_addr, prev_addr);
      if (fb_req && fb_ack) begin
        nack++;
        if (qf.size() == 0) chk(1'b0, "R8 unexpected frame-buffer access", fb_addr, 0);
        else begin
          hf = qf.pop_front();
          chk(fb_we == hf[64] && fb_addr == hf[63:32] && (!hf[64] || fb_wdata == hf[31:0]),
              "R5 R6 frame-buffer access", {fb_we, fb_addr}, hf[64:32]);
        end
        if (fb_err) begin
          qb.delete();
          qf.delete();
          aborted   = 1'b1;
          chk_abort = 1'b1;
        end
      end
      prev_req = fb_req; prev_ack = fb_ack; prev_we = fb_we;
      prev_addr = fb_addr; prev_wd = fb_wdata;
      irq_q = usr_irq;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic setup(int u, bit tofb, int len, int base);
    dcmd[u]  = {tofb ? 8'h80 : 8'h00, 24'(len)};
    dbase[u] = 32'(base);
  endtask

  task automatic raise(logic [NU-1:0] m);
    @(posedge clk);
    #1;
    usr_irq <= usr_irq | m;
  endtask

  task automatic settle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (usr_irq == '0 && usr_sel == '0) q++; else q = 0;
    end
  endtask

  initial begin
    int n0;
    for (int u = 0; u < NU; u++) begin
      for (int i = 0; i < 16; i++) umem[u][i] <= 32'hA000_0000 + 32'(u * 256 + i);
      dcmd[u]  = '0;
      dbase[u] = '0;
    end
    for (int i = 0; i < 64; i++) fbm[i] <= 32'h5500_0000 + 32'(i * 3 + 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(usr_sel == '0 && !bus_stb && !fb_req, "R11 reset state", {usr_sel, bus_stb, fb_req}, 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(usr_sel == '0 && !bus_stb && !fb_req, "R11 after reset", {usr_sel, bus_stb, fb_req}, 0);

    // user-to-frame-buffer, no wait states
    setup(2, 1'b1, 3, 8);
    raise(4'b0100); settle();
    for (int i = 0; i < 3; i++)
      chk(fbm[8 + i] == umem[2][i], "R5 words copied to frame buffer", fbm[8 + i], umem[2][i]);

    // frame-buffer-to-user with wait states
    fb_lat = 2;
    setup(3, 1'b0, 4, 8);
    raise(4'b1000); settle();
    for (int i = 0; i < 4; i++)
      chk(umem[3][i] == fbm[8 + i], "R5 words copied to user", umem[3][i], fbm[8 + i]);

    // zero length
    n0 = nack;
    setup(2, 1'b1, 0, 20);
    raise(4'b0100); settle();
    chk(nack == n0, "R8 zero length no access", nack, n0);

    // all users at once: display first, then rotation (pointer now at user 3)
    fb_lat = 1;
    for (int u = 0; u < NU; u++) setup(u, u[0], 1, 30 + u);
    picks.delete();
    raise(4'b1111); settle();
    chk(picks.size() == 4 && picks[0] == 0 && picks[1] == 1, "R2 display users served first",
        (picks.size() > 1) ? {picks[0], picks[1]} : 0, {32'd0, 32'd1});
    chk(picks.size() == 4 && picks[2] == 3 && picks[3] == 2, "R3 rotation order",
        (picks.size() > 3) ? {picks[2], picks[3]} : 0, {32'd3, 32'd2});

    // display request arriving while an ordinary user is in service
    setup(2, 1'b0, 6, 0);
    setup(0, 1'b1, 2, 50);
    raise(4'b0100);
    repeat (3) @(posedge clk);
    raise(4'b0001); settle();

    // error on the write path and on the read path
    fb_lat = 0;
    setup(3, 1'b1, 3, 40);
    err_arm <= 1'b1;
    raise(4'b1000); settle();
    setup(2, 1'b0, 3, 40);
    fb_lat = 1;
    raise(4'b0100);
    repeat (5) @(posedge clk);
    err_arm <= 1'b1;
    settle();

    // mixed burst after errors
    setup(1, 1'b0, 2, 12);
    setup(2, 1'b1, 5, 16);
    setup(3, 1'b0, 3, 16);
    raise(4'b1110); settle();
    raise(4'b1100); settle();
    finish_run();
  end

endmodule